// File: doc/BRIEF.md
# Source-Node Coherent Read Tracker

This block follows a single coherent read for one cache line from the point of view of the node that asks for it. When the node starts a read, the tracker emits a one-cycle send strobe toward the request channel and opens a transaction. It then collects snoop answers, one per node of a small system whose size is a parameter. These arrive on a response channel. When every node has answered, it emits a one-cycle notice that the home node may order the next request to this line.

The data for the read travels on its own channel. It may be copyback from a peer or memory data from the home node, and both use the same accept input. Data may land before or after the snoop phase closes, and the transaction stays open until it has arrived. A snoop answer flagged as critical warns that dirty copyback data is still on its way. Until that data lands, the tracker raises a flag that blocks a dirty eviction of the line.

Some request types need the node to answer its own snoop. For these the tracker produces the self answer internally and can hold it back on request. A second answer from a node that has already answered sets a sticky error flag.

Top module: `coh_req_tracker`

## Requirements
- R1: After reset, busy, req_send, snoop_done, req_done, evict_block and proto_err are low and rcv_mask is all zeros.
- R2: An issue_valid sampled while idle makes busy high and req_send high for exactly one cycle on the next cycle, with rcv_mask cleared. An issue_valid sampled while busy has no effect: req_send stays low and the open request continues.
- R3: A snoop response (snp_valid with snp_node = i) sampled while busy sets bit i of rcv_mask on the next cycle. A snoop response sampled while idle leaves rcv_mask and proto_err unchanged.
- R4: snoop_done is high for exactly one cycle, in the cycle after the response that completes rcv_mask is sampled, and at most once per request.
- R5: Data (dat_valid) is accepted at most once per request while busy, in either order relative to the snoop phase. In the cycle after both the full mask and the data are present, req_done pulses for one cycle and busy goes low. If the data came first, snoop_done and req_done pulse in the same cycle.
- R6: If issue_self is high when a request is accepted, the self bit (bit SELF_ID, default 0) of rcv_mask is set internally. This happens at the first edge after acceptance at which self_hold is low. It does not happen while self_hold is high.
- R7: A snoop response with snp_crit high, sampled while busy and before the data has arrived, sets evict_block on the next cycle. evict_block goes low in the cycle after the data is accepted.
- R8: A snoop response from a node whose mask bit is already set sets proto_err, which stays high until reset. In self-answer mode, an external response naming SELF_ID is also an error and does not change rcv_mask.
- R9: Data sampled while idle is ignored: the next request still waits for its own data before req_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Start a coherent read |
| issue_self | input | 1 | Request type needs a self snoop answer |
| self_hold | input | 1 | Hold back the self snoop answer |
| snp_valid | input | 1 | Snoop response present |
| snp_node | input | NODE_W | Index of the answering node |
| snp_crit | input | 1 | Response warns of dirty copyback in flight |
| dat_valid | input | 1 | Data response accepted (copyback or memory) |
| busy | output | 1 | A request is open |
| req_send | output | 1 | One-cycle strobe: send request on request channel |
| snoop_done | output | 1 | One-cycle notice to home node: all snoops in |
| req_done | output | 1 | One-cycle strobe: request fully complete |
| evict_block | output | 1 | Dirty eviction of the line must wait |
| proto_err | output | 1 | Sticky duplicate-response error |
| rcv_mask | output | NODES | Snoop responses received, bit i for node i |

## Verification
The hardest situations to reach from the ports are the orderings: data arriving before the last snoop answer, and a critical warning arriving while the data is still pending. The stimulus reaches both with separate requests. One supplies data right after issue and then the answers. The other sends the critical answer first, then the data, then the closing answer, so that evict_block is seen to rise and fall inside one open request. The held self answer is reached by issuing in self mode with self_hold high for several cycles before releasing it. In a separate run, an external answer naming the node's own index is sent before the sticky error is cleared by reset.

// File: rtl/coh_req_tracker.sv
module coh_req_tracker #(
  parameter int NODES   = 3,
  parameter int SELF_ID = 0,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic              issue_self,
  input  logic              self_hold,
  input  logic              snp_valid,
  input  logic [NODE_W-1:0] snp_node,
  input  logic              snp_crit,
  input  logic              dat_valid,
  output logic              busy,
  output logic              req_send,
  output logic              snoop_done,
  output logic              req_done,
  output logic              evict_block,
  output logic              proto_err,
  output logic [NODES-1:0]  rcv_mask
);

  localparam logic [NODES-1:0] ONE      = {{(NODES-1){1'b0}}, 1'b1};
  localparam logic [NODES-1:0] SELF_BIT = ONE << SELF_ID;

  logic busy_q, self_q, sent_q, dat_q, crit_q, err_q;
  logic send_q, sdone_q, rdone_q;
  logic [NODES-1:0] mask_q;

  logic accept, snp_in, ext_self, dup, all_n, dat_n, fin;
  logic [NODES-1:0] ext_bits, self_bits, mask_n;

  assign accept    = issue_valid & ~busy_q;
  assign snp_in    = snp_valid & busy_q;
  assign ext_self  = snp_in & self_q & (snp_node == NODE_W'(SELF_ID));
  assign ext_bits  = (snp_in & ~ext_self) ? (ONE << snp_node) : '0;
  assign self_bits = (busy_q & self_q & ~self_hold) ? SELF_BIT : '0;
  assign dup       = (|(ext_bits & mask_q)) | ext_self;
  assign mask_n    = mask_q | ext_bits | self_bits;
  assign all_n     = &mask_n;
  assign dat_n     = dat_q | (busy_q & dat_valid);
  assign fin       = busy_q & all_n & dat_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      self_q  <= 1'b0;
      sent_q  <= 1'b0;
      dat_q   <= 1'b0;
      crit_q  <= 1'b0;
      err_q   <= 1'b0;
      send_q  <= 1'b0;
      sdone_q <= 1'b0;
      rdone_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      send_q  <= accept;
      sdone_q <= busy_q & all_n & ~sent_q;
      rdone_q <= fin;
      err_q   <= err_q | dup;
      if (accept) begin
        busy_q <= 1'b1;
        self_q <= issue_self;
        mask_q <= '0;
        sent_q <= 1'b0;
        dat_q  <= 1'b0;
        crit_q <= 1'b0;
      end else if (busy_q) begin
        mask_q <= mask_n;
        dat_q  <= dat_n;
        sent_q <= sent_q | all_n;
        crit_q <= (crit_q | (snp_in & snp_crit)) & ~dat_n;
        if (fin) busy_q <= 1'b0;
      end
    end
  end

  assign busy        = busy_q;
  assign req_send    = send_q;
  assign snoop_done  = sdone_q;
  assign req_done    = rdone_q;
  assign evict_block = crit_q;
  assign proto_err   = err_q;
  assign rcv_mask    = mask_q;

  AST_SEND_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    req_send |-> (busy && rcv_mask == '0 && !evict_block)); // R2
  AST_BUSY_ISSUE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && issue_valid) |=> !req_send); // R2
  AST_SNOOP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_done |-> (&rcv_mask)); // R4
  AST_SNOOP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_done |=> !snoop_done); // R4
  AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> (!busy && (&rcv_mask))); // R5
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> req_done); // R5
  AST_EVB_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    evict_block |-> busy); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R8

endmodule

// File: tb/coh_req_tracker_tb.sv
module coh_req_tracker_tb_top;
  localparam int NODES = 3;
  localparam int NODE_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 0, issue_self = 0, self_hold = 0;
  logic snp_valid = 0, snp_crit = 0, dat_valid = 0;
  logic [NODE_W-1:0] snp_node = '0;
  logic busy, req_send, snoop_done, req_done, evict_block, proto_err;
  logic [NODES-1:0] rcv_mask;

  always #2.5 clk = ~clk;

  coh_req_tracker #(.NODES(NODES), .SELF_ID(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_self(issue_self),
    .self_hold(self_hold), .snp_valid(snp_valid), .snp_node(snp_node),
    .snp_crit(snp_crit), .dat_valid(dat_valid), .busy(busy), .req_send(req_send),
    .snoop_done(snoop_done), .req_done(req_done), .evict_block(evict_block),
    .proto_err(proto_err), .rcv_mask(rcv_mask));

  typedef struct {
    logic [8:0] v;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0, cycles = 0;
  logic e_busy, e_send, e_sd, e_rd, e_evb, e_err;
  logic [2:0] e_mask;

  task automatic tick(string tag);
    exp_t e;
    e.v = {e_busy, e_send, e_sd, e_rd, e_evb, e_err, e_mask};
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    issue_valid = 0; issue_self = 0; snp_valid = 0; snp_crit = 0; dat_valid = 0;
    e_send = 0; e_sd = 0; e_rd = 0;
  endtask

  task automatic snp(int node, logic crit);
    snp_valid = 1; snp_node = NODE_W'(node); snp_crit = crit;
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    e_busy = 0; e_send = 0; e_sd = 0; e_rd = 0; e_evb = 0; e_err = 0; e_mask = 3'b000;
    tick("R1 reset state");
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic [8:0] act;
      e = q.pop_front();
      act = {busy, req_send, snoop_done, req_done, evict_block, proto_err, rcv_mask};
      n_cmp++;
      if (act !== e.v) begin
        n_bad++;
        $display("FAIL %s: actual busy,send,sdone,rdone,evb,err,mask=%b expected %b",
                 e.tag, act, e.v);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // Request A: snoops then data
    issue_valid = 1; e_busy = 1; e_send = 1; e_mask = 3'b000; tick("R2 issue accepted");
    issue_valid = 1; snp(1, 0); e_mask = 3'b010; tick("R2 busy issue ignored, R3 node1");
    snp(0, 0); e_mask = 3'b011; tick("R3 node0");
    snp(2, 0); e_mask = 3'b111; e_sd = 1; tick("R4 snoop_done pulse");
    tick("R4 snoop_done single, still open");
    dat_valid = 1; e_busy = 0; e_rd = 1; tick("R5 req_done after data");
    tick("R5 idle after done");

    // idle stimulus ignored
    snp(1, 0); dat_valid = 1; tick("R3 R9 idle snoop and data ignored");

    // Request B: must wait for its own data
    issue_valid = 1; e_busy = 1; e_send = 1; e_mask = 3'b000; tick("R2 issue B");
    snp(0, 0); e_mask = 3'b001; tick("R3 B node0");
    snp(1, 0); e_mask = 3'b011; tick("R3 B node1");
    snp(2, 0); e_mask = 3'b111; e_sd = 1; tick("R9 snoop_done, still waiting data");
    tick("R9 busy without data");
    dat_valid = 1; dat_valid = 1; e_busy = 0; e_rd = 1; tick("R5 B done");

    // Request C: data first
    issue_valid = 1; e_busy = 1; e_send = 1; e_mask = 3'b000; tick("R2 issue C");
    dat_valid = 1; tick("R5 data first keeps busy");
    snp(0, 0); e_mask = 3'b001; tick("R3 C node0");
    snp(1, 0); e_mask = 3'b011; tick("R3 C node1");
    snp(2, 0); e_mask = 3'b111; e_sd = 1; e_rd = 1; e_busy = 0; tick("R5 sdone and rdone together");

    // Request D: critical copyback warning
    issue_valid = 1; e_busy = 1; e_send = 1; e_mask = 3'b000; tick("R2 issue D");
    snp(1, 1); e_mask = 3'b010; e_evb = 1; tick("R7 critical sets evict_block");
    snp(0, 0); e_mask = 3'b011; tick("R7 evict_block held");
    dat_valid = 1; e_evb = 0; tick("R7 evict_block cleared by data");
    snp(2, 0); e_mask = 3'b111; e_sd = 1; e_rd = 1; e_busy = 0; tick("R5 D done");

    // Request E: self answer held back
    issue_valid = 1; issue_self = 1; self_hold = 1; e_busy = 1; e_send = 1; e_mask = 3'b000;
    tick("R6 self issue");
    self_hold = 1; tick("R6 self held");
    self_hold = 1; tick("R6 self still held");
    self_hold = 0; e_mask = 3'b001; tick("R6 self answer released");
    snp(1, 0); e_mask = 3'b011; tick("R6 E node1");
    snp(2, 0); e_mask = 3'b111; e_sd = 1; tick("R6 E snoop_done");
    dat_valid = 1; e_busy = 0; e_rd = 1; tick("R6 E done");
    e_busy = 0; tick("R8 no error so far");

    // Request E2: external self answer in self mode is an error
    issue_valid = 1; issue_self = 1; self_hold = 1; e_busy = 1; e_send = 1; e_mask = 3'b000;
    tick("R8 self issue E2");
    self_hold = 1; snp(0, 0); e_err = 1; tick("R8 external self answer is error");
    self_hold = 1; e_err = 1; tick("R8 err sticky, mask unchanged");

    do_reset();

    // Request F: duplicate response
    issue_valid = 1; e_busy = 1; e_send = 1; e_mask = 3'b000; tick("R2 issue F");
    snp(1, 0); e_mask = 3'b010; tick("R3 F node1");
    snp(1, 0); e_err = 1; tick("R8 duplicate sets error");
    snp(0, 0); e_mask = 3'b011; tick("R8 err sticky");
    snp(2, 0); e_mask = 3'b111; e_sd = 1; tick("R8 F snoop_done");
    dat_valid = 1; e_busy = 0; e_rd = 1; tick("R8 F done, err kept");
    tick("R8 err kept idle");

    @(posedge clk); #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule